// File: doc/BRIEF.md
# Decoupled Instruction Stream Distributor

This block sits right after instruction fetch in a decoupled vector machine. It accepts at most one fetched instruction per cycle. It reads the two-bit class field at the top of the instruction word and sends the instruction to one of three queues. Scalar work goes to the scalar processor queue, loads and stores go to the address-generation queue, and vector arithmetic goes to the vector queue. Each queue keeps program order for the instructions it holds.

The vector queue only offers its oldest entry, and only when a scoreboard reports that both of that entry's source vector registers are ready. A vector instruction stuck at the head waiting for loaded data never holds up fetch. Memory instructions behind it keep flowing into the address queue, so address generation can start early. Fetch stalls only when the queue an instruction is headed for is full.

Top module: `isd_distributor`

## Requirements
- R1: After reset all three queues are empty, `scl_valid`, `adr_valid` and `vec_valid` are low, and `fetch_ready` is high.
- R2: Instruction bits [15:14] select the queue: 00 goes to the scalar queue, 01 to the address queue, 10 to the vector queue, and the unused code 11 goes to the scalar queue.
- R3: Each queue holds 8 entries and presents them to its consumer in the order they were accepted.
- R4: `fetch_ready` is low only when the queue selected by `fetch_instr` is full, and it stays high for any other destination at the same moment.
- R5: `vec_valid` is high exactly when the vector queue is non-empty and both `opnd_ready[vec_instr[7:4]]` and `opnd_ready[vec_instr[3:0]]` are set.
- R6: Vector dispatch is head-only: a younger vector instruction whose operands are ready never dispatches while an older one waits.
- R7: A vector head waiting for operands does not stop memory or scalar instructions from being accepted.
- R8: A take request on a queue whose valid output is low is ignored, and the head entry stays unchanged.
- R9: If a push and a take on the same non-empty queue fall in the same cycle, both happen and the occupancy stays the same. A push toward a full queue is refused even when that queue is being taken from in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetched instruction present |
| fetch_instr | input | 16 | Fetched instruction word |
| fetch_ready | output | 1 | Instruction accepted this cycle when valid |
| opnd_ready | input | 16 | Per vector register ready flags from scoreboard |
| scl_valid | output | 1 | Scalar queue head available |
| scl_instr | output | 16 | Scalar queue head |
| scl_take | input | 1 | Scalar processor consumes head |
| adr_valid | output | 1 | Address queue head available |
| adr_instr | output | 16 | Address queue head |
| adr_take | input | 1 | Address processor consumes head |
| vec_valid | output | 1 | Vector head present with operands ready |
| vec_instr | output | 16 | Vector queue head |
| vec_take | input | 1 | Arithmetic unit accepts head |

## Verification
Two events can land in the same cycle: a memory instruction entering the address queue, and a vector head refusing to dispatch because its sources are not ready. The bench parks a vector instruction whose sources are marked not ready, then fills the whole address queue behind it. It expects every push to be accepted while `vec_valid` stays low. A second overlap is a push and a take on the same queue in one cycle. The bench provokes it on a queue holding one entry and on a full queue, and judges it by draining the queue and comparing the order and count of what comes out.

// File: rtl/isd_pkg.sv
package isd_pkg;
    localparam int NQ = 3;
    typedef enum logic [1:0] {
        Q_SCL = 2'd0,
        Q_ADR = 2'd1,
        Q_VEC = 2'd2
    } qsel_e;
endpackage

// File: rtl/isd_route.sv
module isd_route
    import isd_pkg::*;
#(
    parameter int IW = 16
) (
    input  logic [IW-1:0] instr,
    output qsel_e         dest
);
    logic [1:0] cls;
    assign cls = instr[IW-1 -: 2];

    always_comb begin
        unique case (cls)
            2'b01:   dest = Q_ADR;
            2'b10:   dest = Q_VEC;
            default: dest = Q_SCL;   // 00 and the spare code 11
        endcase
    end
endmodule

// File: rtl/isd_queue.sv
module isd_queue #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } qstate_t;

    qstate_t st_d, st_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = din;
            st_d.wr           = bump(st_q.wr);
        end
        if (pop) begin
            st_d.rd = bump(st_q.rd);
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout  = st_q.mem[st_q.rd];
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    p_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> !empty);
endmodule

// File: rtl/isd_distributor.sv
module isd_distributor
    import isd_pkg::*;
#(
    parameter int IW    = 16,
    parameter int DEPTH = 8,
    parameter int NREG  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_valid,
    input  logic [IW-1:0]   fetch_instr,
    output logic            fetch_ready,
    input  logic [NREG-1:0] opnd_ready,
    output logic            scl_valid,
    output logic [IW-1:0]   scl_instr,
    input  logic            scl_take,
    output logic            adr_valid,
    output logic [IW-1:0]   adr_instr,
    input  logic            adr_take,
    output logic            vec_valid,
    output logic [IW-1:0]   vec_instr,
    input  logic            vec_take
);
    localparam int RW = $clog2(NREG);

    qsel_e            dest;
    logic [NQ-1:0]    q_push, q_pop, q_full, q_empty, q_avail, q_take;
    logic [IW-1:0]    q_head [NQ];
    logic [RW-1:0]    src_a, src_b;
    logic             vec_opnds_ok;

    isd_route #(.IW(IW)) u_route (
        .instr (fetch_instr),
        .dest  (dest)
    );

    assign fetch_ready = !q_full[dest];

    assign src_a        = q_head[Q_VEC][2*RW-1:RW];
    assign src_b        = q_head[Q_VEC][RW-1:0];
    assign vec_opnds_ok = opnd_ready[src_a] && opnd_ready[src_b];

    assign q_take = {vec_take, adr_take, scl_take};

    for (genvar g = 0; g < NQ; g++) begin : g_q
        if (g == int'(Q_VEC)) begin : g_gate
            assign q_avail[g] = !q_empty[g] && vec_opnds_ok;
        end else begin : g_plain
            assign q_avail[g] = !q_empty[g];
        end
        assign q_push[g] = fetch_valid && fetch_ready && (dest == qsel_e'(g));
        assign q_pop[g]  = q_take[g] && q_avail[g];

        isd_queue #(.W(IW), .DEPTH(DEPTH)) u_q (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (q_push[g]),
            .din   (fetch_instr),
            .pop   (q_pop[g]),
            .dout  (q_head[g]),
            .full  (q_full[g]),
            .empty (q_empty[g])
        );
    end

    assign scl_valid = q_avail[Q_SCL];
    assign scl_instr = q_head[Q_SCL];
    assign adr_valid = q_avail[Q_ADR];
    assign adr_instr = q_head[Q_ADR];
    assign vec_valid = q_avail[Q_VEC];
    assign vec_instr = q_head[Q_VEC];

    p_route_adr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_ready && fetch_instr[IW-1 -: 2] == 2'b01) |=> !q_empty[Q_ADR]);
    p_stall_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !fetch_ready) |-> q_full[dest]);
    p_head_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_empty[Q_VEC] && !q_pop[Q_VEC]) |=> $stable(vec_instr));
endmodule

// File: tb/isd_distributor_bench.sv
`timescale 1ns/1ps
module isd_distributor_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [15:0] fetch_instr = '0;
    logic        fetch_ready;
    logic [15:0] opnd_ready = '0;
    logic        scl_valid, adr_valid, vec_valid;
    logic [15:0] scl_instr, adr_instr, vec_instr;
    logic        scl_take = 1'b0, adr_take = 1'b0, vec_take = 1'b0;

    int n_run = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    isd_distributor u_isd_distributor (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_instr(fetch_instr), .fetch_ready(fetch_ready),
        .opnd_ready(opnd_ready),
        .scl_valid(scl_valid), .scl_instr(scl_instr), .scl_take(scl_take),
        .adr_valid(adr_valid), .adr_instr(adr_instr), .adr_take(adr_take),
        .vec_valid(vec_valid), .vec_instr(vec_instr), .vec_take(vec_take)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(input logic [15:0] ins);
        fetch_valid = 1'b1;
        fetch_instr = ins;
        cyc();
        fetch_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 scl_valid", scl_valid, 0);
        chk("R1 adr_valid", adr_valid, 0);
        opnd_ready = 16'hFFFF;
        chk("R1 vec_valid", vec_valid, 0);
        chk("R1 fetch_ready", fetch_ready, 1);
        opnd_ready = '0;

        // R2 routing of every class code
        push(16'h0123);
        chk("R2 scalar", {scl_valid, scl_instr}, {1'b1, 16'h0123});
        push(16'h4567);
        chk("R2 memory", {adr_valid, adr_instr}, {1'b1, 16'h4567});
        push(16'hC9AB);
        scl_take = 1'b1; cyc(); scl_take = 1'b0;
        chk("R2 spare code 11 to scalar", {scl_valid, scl_instr}, {1'b1, 16'hC9AB});
        scl_take = 1'b1; cyc(); scl_take = 1'b0;
        adr_take = 1'b1; cyc(); adr_take = 1'b0;
        chk("R2 queues drained", {scl_valid, adr_valid}, 0);

        // R5 sweep of source register pairs
        for (int a = 0; a < 16; a++) begin
            int b;
            b = (a * 7 + 3) % 16;
            push(16'h8000 | 16'(a << 4) | 16'(b));
            opnd_ready = ~(16'h1 << a);
            #1 chk("R5 src a not ready", vec_valid, 0);
            opnd_ready = ~(16'h1 << b);
            #1 chk("R5 src b not ready", vec_valid, 0);
            opnd_ready = 16'hFFFF;
            #1 chk("R5 both ready", {vec_valid, vec_instr}, {1'b1, 16'h8000 | 16'(a << 4) | 16'(b)});
            vec_take = 1'b1; cyc(); vec_take = 1'b0;
            chk("R5 popped", vec_valid, 0);
            opnd_ready = '0;
        end

        // R7: blocked vector head, memory stream keeps flowing until full
        push(16'h8012);
        push(16'h8034);
        for (int i = 0; i < 8; i++) begin
            fetch_instr = 16'h4000 + 16'(i);
            #1 chk("R7 memory accepted behind blocked vector", fetch_ready, 1);
            push(16'h4000 + 16'(i));
            chk("R7 vector still blocked", vec_valid, 0);
        end
        // R4 stall only for a full destination
        fetch_instr = 16'h4100;
        #1 chk("R4 full address queue stalls", fetch_ready, 0);
        fetch_instr = 16'h0100;
        #1 chk("R4 scalar still accepted", fetch_ready, 1);
        fetch_instr = 16'h8100;
        #1 chk("R4 vector still accepted", fetch_ready, 1);
        fetch_valid = 1'b1; fetch_instr = 16'h4100; cyc(); fetch_valid = 1'b0;
        // R3 order and capacity of the address queue
        for (int i = 0; i < 8; i++) begin
            chk("R3 address order", {adr_valid, adr_instr}, {1'b1, 16'h4000 + 16'(i)});
            adr_take = 1'b1; cyc(); adr_take = 1'b0;
        end
        chk("R3 refused push not stored", adr_valid, 0);

        // R8 take on a blocked head is ignored
        vec_take = 1'b1; cyc(); vec_take = 1'b0;
        // R6 younger entry ready, older not
        opnd_ready = 16'h0018;
        #1 chk("R6 younger not dispatched", vec_valid, 0);
        opnd_ready = 16'hFFFF;
        #1 chk("R8 head unchanged", {vec_valid, vec_instr}, {1'b1, 16'h8012});
        vec_take = 1'b1; cyc();
        chk("R6 second in order", vec_instr, 16'h8034);
        cyc(); vec_take = 1'b0;
        chk("R6 vector queue empty", vec_valid, 0);
        opnd_ready = '0;

        // R9 push and take together on a one-entry queue
        push(16'h0001);
        fetch_valid = 1'b1; fetch_instr = 16'h0002; scl_take = 1'b1;
        cyc();
        fetch_valid = 1'b0;
        chk("R9 new head after push+take", {scl_valid, scl_instr}, {1'b1, 16'h0002});
        cyc(); scl_take = 1'b0;
        chk("R9 occupancy kept at one", scl_valid, 0);

        // R9 full queue: push refused even while taking
        for (int i = 0; i < 8; i++) push(16'h0200 + 16'(i));
        fetch_valid = 1'b1; fetch_instr = 16'h0300; scl_take = 1'b1;
        #1 chk("R9 full queue refuses push", fetch_ready, 0);
        cyc();
        fetch_valid = 1'b0;
        for (int i = 1; i < 8; i++) begin
            chk("R9 drain order", {scl_valid, scl_instr}, {1'b1, 16'h0200 + 16'(i)});
            cyc();
        end
        scl_take = 1'b0;
        chk("R9 refused entry absent", scl_valid, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule